// File: doc/BRIEF.md
# ATA Drive Timing Configuration Engine

This block turns the transfer modes chosen for the two drives on one ATA channel into packed words for a 32-bit access-timing register. A pulse on `start_i` captures each drive's settings. The settings are a present flag, a PIO mode, a multiword DMA mode with its enable, and an Ultra DMA mode with its enable. The engine then looks up the minimum cycle and active times in nanoseconds from built-in tables. It converts each time to controller ticks by ceiling division, done by repeated subtraction. It packs the tick counts into one word per drive and keeps both words.

When the computation finishes, the engine issues one write strobe carrying the word that the register should hold first. It also decides whether the register must be rewritten each time the host selects a drive. That is needed only when the two drives need different, non-zero timing. When that rewrite is enabled, a select pulse produces a write of the selected drive's word on the next cycle.

The parameter `FLAVOR` chooses between two layouts. The generic layout (0) uses 30 ns ticks, recovery offsets and minimum clamps. The enhanced layout (1) uses 15 ns ticks, plain recovery and adds Ultra DMA fields. A mode index above the highest table entry reads that highest entry.

Top module: `ata_tcfg_engine`

## Requirements
- R1: Each nanosecond time becomes ticks by ceiling division: 30 ns per tick when FLAVOR=0, 15 ns per tick when FLAVOR=1. The PIO cycle/active times for modes 0..4 are 600/180, 390/150, 240/105, 180/90 and 120/75 ns. The DMA times for modes 0..2 are 480/240, 165/90 and 120/75 ns. The UDMA times for modes 0..4 are 120/180, 90/150, 60/120, 45/90 and 30/90 ns.
- R2: With FLAVOR=0, a present drive's word holds the PIO active ticks, clamped to a minimum of 1, in bits [4:0]. It holds the PIO recovery ticks in bits [10:5]. Recovery is cycle minus active minus 4, clamped to a minimum of 1.
- R3: With FLAVOR=0 and DMA enabled, the word holds the DMA active ticks in bits [15:11]. It holds the DMA recovery ticks in bits [20:16]. Recovery is cycle minus active minus 1, clamped to a minimum of 1. Bits [31:21] are always zero.
- R4: With FLAVOR=1, PIO active goes in bits [4:0] and PIO recovery (cycle minus active) in bits [9:5]. When DMA is enabled, DMA active goes in bits [14:10] and DMA recovery (cycle minus active) in bits [19:15].
- R5: With FLAVOR=1 and UDMA enabled, bit 20 is set, the UDMA cycle ticks go in bits [24:21] and the UDMA active ticks in bits [28:25]. Bits [31:29] are zero. With FLAVOR=0, the UDMA enable has no effect on the word.
- R6: An absent drive yields an all-zero word. A DMA or UDMA field whose enable is low contributes zeros.
- R7: At the end of a computation, exactly one write is issued if any word is non-zero. The write carries drive 0's word when that word is non-zero, and drive 1's word otherwise. No write is issued when both words are zero.
- R8: `resel_o` is high after a computation only when both words are non-zero and differ. It keeps its value until the next computation ends.
- R9: While idle, a `sel_valid_i` pulse with `resel_o` high writes the word of drive `sel_drive_i` on the next cycle. With `resel_o` low, the pulse produces no write.
- R10: `busy_o` rises in the cycle after an accepted `start_i` and falls when `done_o` pulses. While busy, `start_i` and `sel_valid_i` are ignored. A same-cycle `start_i` takes precedence over a select.
- R11: After reset, `busy_o`, `done_o`, `reg_wr_o` and `resel_o` are low, and both stored words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture settings and begin computation |
| present_i | input | 2 | Drive present flag, bit d for drive d |
| pio_mode_i | input | 6 | PIO mode, 3 bits per drive, drive 0 in [2:0] |
| dma_en_i | input | 2 | Multiword DMA enable per drive |
| dma_mode_i | input | 4 | DMA mode, 2 bits per drive, drive 0 in [1:0] |
| udma_en_i | input | 2 | Ultra DMA enable per drive |
| udma_mode_i | input | 6 | UDMA mode, 3 bits per drive, drive 0 in [2:0] |
| sel_valid_i | input | 1 | Drive select pulse |
| sel_drive_i | input | 1 | Drive being selected |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse at the end of a computation |
| reg_wr_o | output | 1 | One-cycle timing register write strobe |
| reg_data_o | output | WORD_W | Word carried by the write strobe |
| resel_o | output | 1 | Rewrite on each drive select is enabled |

## Verification
Both flavours are instantiated side by side on the same stimulus. This shows where the tick period, offsets, clamps and UDMA fields make the two layouts diverge.

The patterns used are:
- two present drives with different settings, where both words are written and the per-select rewrite is enabled;
- two identical drives, where the rewrite stays off and a select must be silent;
- a missing drive 0, where drive 1's word is written instead;
- two absent drives, where nothing is written;
- a sweep through every PIO, DMA and UDMA mode, which exercises every table entry and the clamps.

One pattern differs only in the UDMA enable. It separates the flavours: the rewrite turns on in the enhanced layout and stays off in the generic one. A further run changes inputs and pulses start and select mid-computation, to show that captured settings are kept and that a busy engine ignores both pulses.

// File: rtl/ata_tcfg_pkg.sv
package ata_tcfg_pkg;

   localparam int NUM_DRV   = 2;
   localparam int NUM_ITEMS = 6;
   localparam int MODE_W    = 3;

   typedef enum logic [2:0] {
      IT_PIO_CYC  = 3'd0,
      IT_PIO_ACT  = 3'd1,
      IT_DMA_CYC  = 3'd2,
      IT_DMA_ACT  = 3'd3,
      IT_UDMA_CYC = 3'd4,
      IT_UDMA_ACT = 3'd5
   } item_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_PACK,
      ST_COMMIT
   } state_e;

   typedef struct packed {
      logic              present;
      logic [MODE_W-1:0] pio;
      logic              dma_en;
      logic [1:0]        dma;
      logic              udma_en;
      logic [MODE_W-1:0] udma;
   } drv_cfg_t;

   // generic layout field placement
   localparam int GN_PACT_LSB = 0;
   localparam int GN_PACT_W   = 5;
   localparam int GN_PREC_LSB = 5;
   localparam int GN_PREC_W   = 6;
   localparam int GN_DACT_LSB = 11;
   localparam int GN_DACT_W   = 5;
   localparam int GN_DREC_LSB = 16;
   localparam int GN_DREC_W   = 5;
   localparam int GN_PIO_REC_OFS = 4;
   localparam int GN_DMA_REC_OFS = 1;

   // enhanced layout field placement
   localparam int EN_PACT_LSB = 0;
   localparam int EN_PACT_W   = 5;
   localparam int EN_PREC_LSB = 5;
   localparam int EN_PREC_W   = 5;
   localparam int EN_DACT_LSB = 10;
   localparam int EN_DACT_W   = 5;
   localparam int EN_DREC_LSB = 15;
   localparam int EN_DREC_W   = 5;
   localparam int EN_UDMA_BIT = 20;
   localparam int EN_UCYC_LSB = 21;
   localparam int EN_UCYC_W   = 4;
   localparam int EN_UACT_LSB = 25;
   localparam int EN_UACT_W   = 4;

   localparam int MIN_WORD_W = 29;

endpackage

// File: rtl/ata_tcfg_rom.sv
module ata_tcfg_rom
   import ata_tcfg_pkg::*;
#(
   parameter int NS_W = 10
) (
   input  item_e             item_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [NS_W-1:0]   ns_o
);

   if (NS_W < 10) begin : g_bad_ns_w
      $error("ata_tcfg_rom: NS_W must hold 600");
   end

   logic [MODE_W-1:0] m5;
   logic [MODE_W-1:0] m3;

   always_comb begin
      m5 = (mode_i > 3'd4) ? 3'd4 : mode_i;
      m3 = (mode_i > 3'd2) ? 3'd2 : mode_i;
   end

   always_comb begin
      ns_o = '0;
      unique case (item_i)
         IT_PIO_CYC: begin
            case (m5)
               3'd0:    ns_o = NS_W'(600);
               3'd1:    ns_o = NS_W'(390);
               3'd2:    ns_o = NS_W'(240);
               3'd3:    ns_o = NS_W'(180);
               default: ns_o = NS_W'(120);
            endcase
         end
         IT_PIO_ACT: begin
            case (m5)
               3'd0:    ns_o = NS_W'(180);
               3'd1:    ns_o = NS_W'(150);
               3'd2:    ns_o = NS_W'(105);
               3'd3:    ns_o = NS_W'(90);
               default: ns_o = NS_W'(75);
            endcase
         end
         IT_DMA_CYC: begin
            case (m3)
               3'd0:    ns_o = NS_W'(480);
               3'd1:    ns_o = NS_W'(165);
               default: ns_o = NS_W'(120);
            endcase
         end
         IT_DMA_ACT: begin
            case (m3)
               3'd0:    ns_o = NS_W'(240);
               3'd1:    ns_o = NS_W'(90);
               default: ns_o = NS_W'(75);
            endcase
         end
         IT_UDMA_CYC: begin
            case (m5)
               3'd0:    ns_o = NS_W'(120);
               3'd1:    ns_o = NS_W'(90);
               3'd2:    ns_o = NS_W'(60);
               3'd3:    ns_o = NS_W'(45);
               default: ns_o = NS_W'(30);
            endcase
         end
         IT_UDMA_ACT: begin
            case (m5)
               3'd0:    ns_o = NS_W'(180);
               3'd1:    ns_o = NS_W'(150);
               3'd2:    ns_o = NS_W'(120);
               default: ns_o = NS_W'(90);
            endcase
         end
         default: ns_o = '0;
      endcase
   end

endmodule

// File: rtl/ata_tcfg_ceil_div.sv
module ata_tcfg_ceil_div #(
   parameter int NS_W    = 10,
   parameter int Q_W     = 7,
   parameter int TICK_NS = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [NS_W-1:0] ns_i,
   output logic            done_o,
   output logic [Q_W-1:0]  q_o
);

   localparam logic [NS_W-1:0] TICK = NS_W'(TICK_NS);

   if (TICK_NS < 1) begin : g_bad_tick
      $error("ata_tcfg_ceil_div: TICK_NS must be positive");
   end
   if ((1 << Q_W) <= ((1 << NS_W) / TICK_NS)) begin : g_bad_q_w
      $error("ata_tcfg_ceil_div: Q_W too narrow for NS_W/TICK_NS");
   end

   logic [NS_W-1:0] rem_q;
   logic [Q_W-1:0]  cnt_q;
   logic            run_q;
   logic            done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_i) begin
            rem_q <= ns_i;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (rem_q == '0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               rem_q <= (rem_q > TICK) ? (rem_q - TICK) : '0;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign q_o    = cnt_q;

endmodule

// File: rtl/ata_tcfg_pack.sv
module ata_tcfg_pack
   import ata_tcfg_pkg::*;
#(
   parameter int FLAVOR = 1,
   parameter int WORD_W = 32,
   parameter int TICK_W = 7
) (
   input  drv_cfg_t                         cfg_i,
   input  logic [NUM_ITEMS-1:0][TICK_W-1:0] tk_i,
   output logic [WORD_W-1:0]                word_o
);

   int pc, pa, pr, dc, da, dr, uc, ua;

   always_comb begin
      pc = int'(tk_i[IT_PIO_CYC]);
      pa = int'(tk_i[IT_PIO_ACT]);
      dc = int'(tk_i[IT_DMA_CYC]);
      da = int'(tk_i[IT_DMA_ACT]);
      uc = int'(tk_i[IT_UDMA_CYC]);
      ua = int'(tk_i[IT_UDMA_ACT]);
   end

   if (FLAVOR == 0) begin : g_generic
      always_comb begin
         pa = (int'(tk_i[IT_PIO_ACT]) < 1) ? 1 : int'(tk_i[IT_PIO_ACT]);
         pr = pc - pa - GN_PIO_REC_OFS;
         if (pr < 1) pr = 1;
         dr = dc - da - GN_DMA_REC_OFS;
         if (dr < 1) dr = 1;
         word_o = '0;
         if (cfg_i.present) begin
            word_o[GN_PACT_LSB +: GN_PACT_W] = pa[GN_PACT_W-1:0];
            word_o[GN_PREC_LSB +: GN_PREC_W] = pr[GN_PREC_W-1:0];
            if (cfg_i.dma_en) begin
               word_o[GN_DACT_LSB +: GN_DACT_W] = da[GN_DACT_W-1:0];
               word_o[GN_DREC_LSB +: GN_DREC_W] = dr[GN_DREC_W-1:0];
            end
         end
      end
   end else begin : g_enhanced
      always_comb begin
         pr = pc - int'(tk_i[IT_PIO_ACT]);
         dr = dc - da;
         word_o = '0;
         if (cfg_i.present) begin
            word_o[EN_PACT_LSB +: EN_PACT_W] = tk_i[IT_PIO_ACT][EN_PACT_W-1:0];
            word_o[EN_PREC_LSB +: EN_PREC_W] = pr[EN_PREC_W-1:0];
            if (cfg_i.dma_en) begin
               word_o[EN_DACT_LSB +: EN_DACT_W] = da[EN_DACT_W-1:0];
               word_o[EN_DREC_LSB +: EN_DREC_W] = dr[EN_DREC_W-1:0];
            end
            if (cfg_i.udma_en) begin
               word_o[EN_UDMA_BIT]              = 1'b1;
               word_o[EN_UCYC_LSB +: EN_UCYC_W] = uc[EN_UCYC_W-1:0];
               word_o[EN_UACT_LSB +: EN_UACT_W] = ua[EN_UACT_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/ata_tcfg_engine.sv
module ata_tcfg_engine
   import ata_tcfg_pkg::*;
#(
   parameter int FLAVOR = 1,
   parameter int WORD_W = 32,
   parameter int TICK_W = 7,
   parameter int NS_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        present_i,
   input  logic [5:0]        pio_mode_i,
   input  logic [1:0]        dma_en_i,
   input  logic [3:0]        dma_mode_i,
   input  logic [1:0]        udma_en_i,
   input  logic [5:0]        udma_mode_i,
   input  logic              sel_valid_i,
   input  logic              sel_drive_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              reg_wr_o,
   output logic [WORD_W-1:0] reg_data_o,
   output logic              resel_o
);

   localparam int    TICK_NS   = (FLAVOR == 0) ? 30 : 15;
   localparam item_e LAST_ITEM = (FLAVOR == 0) ? IT_DMA_ACT : IT_UDMA_ACT;

   if (FLAVOR != 0 && FLAVOR != 1) begin : g_bad_flavor
      $error("ata_tcfg_engine: FLAVOR must be 0 or 1");
   end
   if (WORD_W < MIN_WORD_W) begin : g_bad_word_w
      $error("ata_tcfg_engine: WORD_W too narrow for the field layout");
   end

   // capture view of the inputs, one entry per drive
   drv_cfg_t cfg_in [NUM_DRV];
   for (genvar d = 0; d < NUM_DRV; d++) begin : g_cfg
      assign cfg_in[d] = '{present: present_i[d],
                           pio:     pio_mode_i[d*MODE_W +: MODE_W],
                           dma_en:  dma_en_i[d],
                           dma:     dma_mode_i[d*2 +: 2],
                           udma_en: udma_en_i[d],
                           udma:    udma_mode_i[d*MODE_W +: MODE_W]};
   end

   state_e                          state_q;
   item_e                           item_q;
   logic                            drv_q;
   drv_cfg_t                        cfg_q [NUM_DRV];
   logic [NUM_ITEMS-1:0][TICK_W-1:0] tk_q;
   logic [WORD_W-1:0]               word_q [NUM_DRV];
   logic                            resel_q;
   logic                            wr_q;
   logic [WORD_W-1:0]               data_q;
   logic                            done_q;

   logic [MODE_W-1:0] rom_mode;
   logic [NS_W-1:0]   rom_ns;
   logic              div_load;
   logic              div_done;
   logic [TICK_W-1:0] div_q;
   logic [WORD_W-1:0] pack_word;
   logic [WORD_W-1:0] word0_w;
   logic [WORD_W-1:0] word1_w;

   assign word0_w = word_q[0];
   assign word1_w = word_q[1];

   always_comb begin
      unique case (item_q)
         IT_PIO_CYC, IT_PIO_ACT: rom_mode = cfg_q[drv_q].pio;
         IT_DMA_CYC, IT_DMA_ACT: rom_mode = {1'b0, cfg_q[drv_q].dma};
         default:                rom_mode = cfg_q[drv_q].udma;
      endcase
   end

   assign div_load = (state_q == ST_ISSUE);

   ata_tcfg_rom #(.NS_W(NS_W)) u_rom (
      .item_i (item_q),
      .mode_i (rom_mode),
      .ns_o   (rom_ns)
   );

   ata_tcfg_ceil_div #(.NS_W(NS_W), .Q_W(TICK_W), .TICK_NS(TICK_NS)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (div_load),
      .ns_i   (rom_ns),
      .done_o (div_done),
      .q_o    (div_q)
   );

   ata_tcfg_pack #(.FLAVOR(FLAVOR), .WORD_W(WORD_W), .TICK_W(TICK_W)) u_pack (
      .cfg_i  (cfg_q[drv_q]),
      .tk_i   (tk_q),
      .word_o (pack_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         item_q  <= IT_PIO_CYC;
         drv_q   <= 1'b0;
         tk_q    <= '0;
         resel_q <= 1'b0;
         wr_q    <= 1'b0;
         data_q  <= '0;
         done_q  <= 1'b0;
         for (int d = 0; d < NUM_DRV; d++) begin
            cfg_q[d]  <= '0;
            word_q[d] <= '0;
         end
      end else begin
         wr_q   <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  for (int d = 0; d < NUM_DRV; d++) cfg_q[d] <= cfg_in[d];
                  drv_q   <= 1'b0;
                  item_q  <= IT_PIO_CYC;
                  state_q <= ST_ISSUE;
               end else if (sel_valid_i && resel_q) begin
                  wr_q   <= 1'b1;
                  data_q <= word_q[sel_drive_i];
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (div_done) begin
                  tk_q[item_q] <= div_q;
                  if (item_q == LAST_ITEM) begin
                     state_q <= ST_PACK;
                  end else begin
                     item_q  <= item_e'(item_q + 3'd1);
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_PACK: begin
               word_q[drv_q] <= pack_word;
               if (drv_q == 1'b1) begin
                  state_q <= ST_COMMIT;
               end else begin
                  drv_q   <= 1'b1;
                  item_q  <= IT_PIO_CYC;
                  state_q <= ST_ISSUE;
               end
            end
            ST_COMMIT: begin
               resel_q <= (word0_w != '0) && (word1_w != '0) && (word0_w != word1_w);
               if (word0_w != '0) begin
                  wr_q   <= 1'b1;
                  data_q <= word0_w;
               end else if (word1_w != '0) begin
                  wr_q   <= 1'b1;
                  data_q <= word1_w;
               end
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign reg_wr_o   = wr_q;
   assign reg_data_o = data_q;
   assign resel_o    = resel_q;

endmodule

// File: rtl/ata_tcfg_engine_chk.sv
module ata_tcfg_engine_chk #(
   parameter int FLAVOR = 1,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              sel_valid_i,
   input logic              sel_drive_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              reg_wr_o,
   input logic [WORD_W-1:0] reg_data_o,
   input logic              resel_o,
   input logic [WORD_W-1:0] word0_w,
   input logic [WORD_W-1:0] word1_w
);

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_wr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (reg_data_o != '0));

   p_resel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(resel_o));

   p_sel_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i && sel_valid_i && resel_o) |=>
         (reg_wr_o && reg_data_o == ($past(sel_drive_i) ? $past(word1_w) : $past(word0_w))));

   p_sel_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !resel_o) |=> !reg_wr_o);

   if (FLAVOR == 0) begin : g_gen_chk
      p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         reg_wr_o |-> (reg_data_o[WORD_W-1:21] == '0));
   end else begin : g_enh_chk
      p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         reg_wr_o |-> (reg_data_o[WORD_W-1:29] == '0));
   end

endmodule

bind ata_tcfg_engine ata_tcfg_engine_chk #(.FLAVOR(FLAVOR), .WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .sel_valid_i (sel_valid_i),
   .sel_drive_i (sel_drive_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .reg_wr_o    (reg_wr_o),
   .reg_data_o  (reg_data_o),
   .resel_o     (resel_o),
   .word0_w     (word0_w),
   .word1_w     (word1_w)
);

// File: tb/ata_tcfg_engine_tb_top.sv
`timescale 1ns/1ps
module ata_tcfg_engine_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       start = 1'b0;
   logic       sel_valid = 1'b0;
   logic       sel_drive = 1'b0;
   bit         pres [2];
   bit         de [2];
   bit         ue [2];
   int         pm [2];
   int         dm [2];
   int         um [2];
   logic [1:0] present_v, dma_en_v, udma_en_v;
   logic [5:0] pio_v, udma_v;
   logic [3:0] dma_v;

   always_comb begin
      for (int d = 0; d < 2; d++) begin
         present_v[d]      = pres[d];
         dma_en_v[d]       = de[d];
         udma_en_v[d]      = ue[d];
         pio_v[d*3 +: 3]   = 3'(pm[d]);
         dma_v[d*2 +: 2]   = 2'(dm[d]);
         udma_v[d*3 +: 3]  = 3'(um[d]);
      end
   end

   logic        busy_e, done_e, wr_e, resel_e;
   logic [31:0] data_e;
   logic        busy_g, done_g, wr_g, resel_g;
   logic [31:0] data_g;

   ata_tcfg_engine #(.FLAVOR(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .present_i(present_v),
      .pio_mode_i(pio_v), .dma_en_i(dma_en_v), .dma_mode_i(dma_v),
      .udma_en_i(udma_en_v), .udma_mode_i(udma_v), .sel_valid_i(sel_valid),
      .sel_drive_i(sel_drive), .busy_o(busy_e), .done_o(done_e),
      .reg_wr_o(wr_e), .reg_data_o(data_e), .resel_o(resel_e));

   ata_tcfg_engine #(.FLAVOR(0)) dut_g_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .present_i(present_v),
      .pio_mode_i(pio_v), .dma_en_i(dma_en_v), .dma_mode_i(dma_v),
      .udma_en_i(udma_en_v), .udma_mode_i(udma_v), .sel_valid_i(sel_valid),
      .sel_drive_i(sel_drive), .busy_o(busy_g), .done_o(done_g),
      .reg_wr_o(wr_g), .reg_data_o(data_g), .resel_o(resel_g));

   // reference timing tables in nanoseconds
   int pio_c [5] = '{600, 390, 240, 180, 120};
   int pio_a [5] = '{180, 150, 105, 90, 75};
   int dma_c [3] = '{480, 165, 120};
   int dma_a [3] = '{240, 90, 75};
   int ud_c  [5] = '{120, 90, 60, 45, 30};
   int ud_a  [5] = '{180, 150, 120, 90, 90};

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   int    q_e [$];
   int    q_g [$];
   string t_e [$];
   string t_g [$];
   int    mw_e [2];
   int    mw_g [2];
   bit    mr_e, mr_g;

   function automatic int cdiv(int ns, int t);
      return (ns + t - 1) / t;
   endfunction

   function automatic int calc(bit enh, int d);
      int w, t, pc, pa, pr, dc, da, dr;
      w = 0;
      t = enh ? 15 : 30;
      if (!pres[d]) return 0;
      pc = cdiv(pio_c[pm[d]], t);
      pa = cdiv(pio_a[pm[d]], t);
      dc = cdiv(dma_c[dm[d]], t);
      da = cdiv(dma_a[dm[d]], t);
      if (!enh) begin
         if (pa < 1) pa = 1;
         pr = pc - pa - 4; if (pr < 1) pr = 1;
         dr = dc - da - 1; if (dr < 1) dr = 1;
         w = pa | (pr << 5);
         if (de[d]) w |= (da << 11) | (dr << 16);
      end else begin
         w = pa | ((pc - pa) << 5);
         if (de[d]) w |= (da << 10) | ((dc - da) << 15);
         if (ue[d]) w |= (1 << 20) | (cdiv(ud_c[um[d]], t) << 21) | (cdiv(ud_a[um[d]], t) << 25);
      end
      return w;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // every-clock comparison of the write strobes against the model queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_e) begin
            if (q_e.size() == 0) check(1'b0, "R9", "dut_i unexpected write", int'(data_e), 0);
            else begin
               int    x;
               string tg;
               x  = q_e.pop_front();
               tg = t_e.pop_front();
               check(int'(data_e) == x, tg, "dut_i write word", int'(data_e), x);
            end
         end
         if (wr_g) begin
            if (q_g.size() == 0) check(1'b0, "R9", "dut_g_i unexpected write", int'(data_g), 0);
            else begin
               int    x;
               string tg;
               x  = q_g.pop_front();
               tg = t_g.pop_front();
               check(int'(data_g) == x, tg, "dut_g_i write word", int'(data_g), x);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(1'b0, "R10", "watchdog expired", cyc, 150000);
         report();
      end
   end

   task automatic run(string tag, bit disturb);
      bit got_e, got_g;
      for (int d = 0; d < 2; d++) begin
         mw_e[d] = calc(1'b1, d);
         mw_g[d] = calc(1'b0, d);
      end
      if (mw_e[0] != 0) begin q_e.push_back(mw_e[0]); t_e.push_back({tag, " R7"}); end
      else if (mw_e[1] != 0) begin q_e.push_back(mw_e[1]); t_e.push_back({tag, " R7"}); end
      if (mw_g[0] != 0) begin q_g.push_back(mw_g[0]); t_g.push_back({tag, " R7"}); end
      else if (mw_g[1] != 0) begin q_g.push_back(mw_g[1]); t_g.push_back({tag, " R7"}); end
      mr_e = (mw_e[0] != 0) && (mw_e[1] != 0) && (mw_e[0] != mw_e[1]);
      mr_g = (mw_g[0] != 0) && (mw_g[1] != 0) && (mw_g[0] != mw_g[1]);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy_e && busy_g, "R10", "busy after start", int'({busy_e, busy_g}), 3);
      if (disturb) begin
         repeat (3) @(negedge clk);
         pres[0] = ~pres[0]; pm[0] = (pm[0] + 1) % 5; de[1] = ~de[1];
         start = 1'b1; sel_valid = 1'b1; sel_drive = 1'b1;
         @(negedge clk);
         start = 1'b0; sel_valid = 1'b0;
      end
      got_e = 0; got_g = 0;
      for (int i = 0; i < 5000 && !(got_e && got_g); i++) begin
         @(negedge clk);
         if (done_e) begin
            got_e = 1;
            check(resel_e == mr_e, "R8", {tag, " dut_i resel"}, int'(resel_e), int'(mr_e));
            check(!busy_e, "R10", "dut_i idle at done", int'(busy_e), 0);
         end
         if (done_g) begin
            got_g = 1;
            check(resel_g == mr_g, "R8", {tag, " dut_g_i resel"}, int'(resel_g), int'(mr_g));
         end
      end
      check(got_e && got_g, "R10", {tag, " done seen"}, int'({got_e, got_g}), 3);
      repeat (2) @(negedge clk);
      check(q_e.size() == 0 && q_g.size() == 0, "R7", {tag, " writes issued"},
            q_e.size() + q_g.size(), 0);
   endtask

   task automatic do_sel(int d);
      if (mr_e) begin q_e.push_back(mw_e[d]); t_e.push_back("R9 select"); end
      if (mr_g) begin q_g.push_back(mw_g[d]); t_g.push_back("R9 select"); end
      @(negedge clk); sel_valid = 1'b1; sel_drive = d[0];
      @(negedge clk); sel_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(q_e.size() == 0 && q_g.size() == 0, "R9", "select writes", q_e.size() + q_g.size(), 0);
   endtask

   task automatic set_drv(int d, bit p, int pmode, bit dmae, int dmode, bit ude, int umode);
      pres[d] = p; pm[d] = pmode; de[d] = dmae; dm[d] = dmode; ue[d] = ude; um[d] = umode;
   endtask

   initial begin
      set_drv(0, 0, 0, 0, 0, 0, 0);
      set_drv(1, 0, 0, 0, 0, 0, 0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!busy_e && !done_e && !wr_e && !resel_e, "R11", "dut_i reset state",
            int'({busy_e, done_e, wr_e, resel_e}), 0);
      check(!busy_g && !done_g && !wr_g && !resel_g, "R11", "dut_g_i reset state",
            int'({busy_g, done_g, wr_g, resel_g}), 0);
      do_sel(1);

      // R1 R2 R3 R4 R5: differing drives
      set_drv(0, 1, 4, 1, 2, 1, 4);
      set_drv(1, 1, 0, 0, 0, 0, 0);
      run("R1 R2 R3 R4 R5 differ", 1'b0);
      do_sel(1);
      do_sel(0);

      // R8: identical drives, no rewrite
      set_drv(0, 1, 3, 1, 1, 1, 3);
      set_drv(1, 1, 3, 1, 1, 1, 3);
      run("R8 identical", 1'b0);
      do_sel(1);

      // R5: UDMA enable only -> generic words equal, enhanced differ
      set_drv(0, 1, 2, 0, 0, 1, 2);
      set_drv(1, 1, 2, 0, 0, 0, 0);
      run("R5 udma only", 1'b0);
      do_sel(1);

      // R6: drive 0 absent
      set_drv(0, 0, 4, 1, 2, 1, 4);
      set_drv(1, 1, 2, 1, 0, 1, 2);
      run("R6 drive0 absent", 1'b0);
      do_sel(0);

      // R6 R7: both absent
      set_drv(0, 0, 1, 1, 1, 1, 1);
      set_drv(1, 0, 1, 1, 1, 1, 1);
      run("R6 both absent", 1'b0);

      // R1 R2 R4: mode sweep over all table entries
      for (int m = 0; m < 5; m++) begin
         set_drv(0, 1, m, 1, m % 3, 1, m);
         set_drv(1, 1, 4 - m, 0, 2, 0, 4);
         run("R1 R2 R4 sweep", 1'b0);
         do_sel(1);
      end

      // R10: start and select ignored while busy
      set_drv(0, 1, 1, 1, 0, 1, 1);
      set_drv(1, 1, 0, 1, 2, 0, 0);
      run("R10 busy ignore", 1'b1);
      do_sel(0);

      report();
   end

endmodule